// File: doc/BRIEF.md
# Rotated Immediate Encodability Checker

The block decides whether a 32-bit constant can be carried inside an instruction as a short immediate. That short form is an 8-bit value rotated right by an even number of bit positions, from 0 to 30. If the constant fits, the block returns the 8-bit value and a 4-bit rotate field. The right-rotate amount is twice the field.

The block runs two searches side by side. One works on the constant as given. The other works on its bitwise complement, so that a code generator can fall back to a complement-move form when the direct form fails. Small negative numbers are the usual case for this. If the direct form fits, the block reports that encoding. If only the complement fits, it reports the encoding of the complement. If neither fits, both flags are low and the encoding fields read zero.

The search is combinational and tries every even rotation at once. The result is captured in a single register stage whenever `valid_in` is high, and it appears on the outputs one clock later together with `valid_out`.

Top module: `rotimm_check`

## Requirements
- R1: `valid_out` is high in exactly the cycles that follow a clock edge at which `valid_in` was high, and is low otherwise.
- R2: Every input from 0x00000000 to 0x000000FF gives `direct_ok`=1, `rot_out`=0 and `imm_out` equal to the input's low byte.
- R3: `direct_ok` is 1 exactly when some left rotation of the input by 2*k bits (k in 0..15) leaves bits 31..8 all zero. When it is 1, `imm_out` rotated right by 2*`rot_out` equals the captured input.
- R4: When several rotations fit, `rot_out` is the smallest fitting k. For example, 0x00000003 gives rot 0 and imm 0x03, and 0x000000C0 gives rot 0 and imm 0xC0.
- R5: `inverted_ok` is 1 exactly when the bitwise complement of the input satisfies the fit condition of R3. It is computed independently of `direct_ok`.
- R6: When `direct_ok` is 0 and `inverted_ok` is 1, `imm_out`/`rot_out` encode the complement. For example, 0xFFFFFFF6 gives imm 0x09 and rot 0, and 0xFFFFFFFF gives imm 0x00 and rot 0.
- R7: When neither form fits, both flags are 0 and `imm_out`=0 and `rot_out`=0. For example, 0x1999999A gives this result.
- R8: Fits that wrap around bit 31 are found. 0xF000000F gives imm 0xFF rot 2, 0x00000400 gives imm 0x01 rot 11, and 0x000003FC gives imm 0xFF rot 15.
- R9: In a cycle after an edge at which `valid_in` was low, `direct_ok`, `inverted_ok`, `imm_out` and `rot_out` keep the values they had before that edge.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Capture strobe for `data_in` |
| data_in | input | 32 | Constant to classify |
| valid_out | output | 1 | Result registers were loaded at the last edge |
| direct_ok | output | 1 | Constant fits as a rotated 8-bit value |
| inverted_ok | output | 1 | Complement of the constant fits |
| imm_out | output | 8 | 8-bit value of the reported encoding |
| rot_out | output | 4 | Rotate field (right-rotate amount / 2) |

## Verification
The assertions assume that `data_in` holds steady from the capture edge onward only in the sense that `$past` recovers it. They also assume that `valid_in` is a clean level sampled at each rising edge, with no further protocol. The bench drives both inputs on the falling edge, so every capture edge sees settled values. The stimulus mixes several kinds of input. Encodable constants are built by rotating random bytes, so the direct search finds hits across all sixteen rotations. Small negative numbers exercise the complement path. Arbitrary words mostly fail both searches. Idle cycles are inserted so that the hold behaviour is seen between results.

// File: rtl/rimm_pkg.sv
package rimm_pkg;

   // Which of the two candidate encodings is reported
   typedef enum logic [1:0] {
      FORM_NONE   = 2'd0,
      FORM_DIRECT = 2'd1,
      FORM_INVERT = 2'd2
   } rimm_form_e;

   localparam int unsigned DEF_DATA_W   = 32;
   localparam int unsigned DEF_IMM_W    = 8;
   localparam int unsigned DEF_ROT_STEP = 2;

endpackage

// File: rtl/rimm_probe.sv
// One rotation candidate: rotate left by SHIFT and test whether the
// result fits in the low IMM_W bits.
module rimm_probe #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 8,
   parameter int unsigned SHIFT  = 0
) (
   input  logic [DATA_W-1:0] word_i,
   output logic              fit_o,
   output logic [IMM_W-1:0]  imm_o
);

   logic [DATA_W-1:0] turned;

   generate
      if (SHIFT == 0) begin : g_plain
         assign turned = word_i;
      end else begin : g_turn
         assign turned = {word_i[DATA_W-SHIFT-1:0], word_i[DATA_W-1:DATA_W-SHIFT]};
      end
   endgenerate

   assign fit_o = ~|turned[DATA_W-1:IMM_W];
   assign imm_o = turned[IMM_W-1:0];

endmodule

// File: rtl/rimm_search.sv
// Tries every even rotation in parallel and keeps the smallest one that fits.
module rimm_search #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IMM_W    = 8,
   parameter int unsigned ROT_STEP = 2,
   localparam int unsigned NUM_ROT = DATA_W / ROT_STEP,
   localparam int unsigned ROT_W   = $clog2(NUM_ROT)
) (
   input  logic [DATA_W-1:0] word_i,
   output logic              found_o,
   output logic [IMM_W-1:0]  imm_o,
   output logic [ROT_W-1:0]  rot_o
);

   logic [NUM_ROT-1:0] fit_vec;
   logic [IMM_W-1:0]   imm_arr [NUM_ROT];

   generate
      for (genvar k = 0; k < NUM_ROT; k++) begin : g_probe
         rimm_probe #(
            .DATA_W (DATA_W),
            .IMM_W  (IMM_W),
            .SHIFT  (k * ROT_STEP)
         ) u_probe (
            .word_i (word_i),
            .fit_o  (fit_vec[k]),
            .imm_o  (imm_arr[k])
         );
      end
   endgenerate

   // Scan from the top down so the lowest fitting index wins
   always_comb begin
      found_o = 1'b0;
      imm_o   = '0;
      rot_o   = '0;
      for (int k = NUM_ROT - 1; k >= 0; k--) begin
         if (fit_vec[k]) begin
            found_o = 1'b1;
            imm_o   = imm_arr[k];
            rot_o   = ROT_W'(k);
         end
      end
   end

endmodule

// File: rtl/rimm_select.sv
// Chooses between the direct and the complemented encoding.
module rimm_select
   import rimm_pkg::*;
#(
   parameter int unsigned IMM_W = 8,
   parameter int unsigned ROT_W = 4
) (
   input  logic             dir_found_i,
   input  logic [IMM_W-1:0] dir_imm_i,
   input  logic [ROT_W-1:0] dir_rot_i,
   input  logic             inv_found_i,
   input  logic [IMM_W-1:0] inv_imm_i,
   input  logic [ROT_W-1:0] inv_rot_i,
   output logic [IMM_W-1:0] imm_o,
   output logic [ROT_W-1:0] rot_o
);

   rimm_form_e form;

   always_comb begin
      if (dir_found_i)      form = FORM_DIRECT;
      else if (inv_found_i) form = FORM_INVERT;
      else                  form = FORM_NONE;
   end

   always_comb begin
      unique case (form)
         FORM_DIRECT: begin
            imm_o = dir_imm_i;
            rot_o = dir_rot_i;
         end
         FORM_INVERT: begin
            imm_o = inv_imm_i;
            rot_o = inv_rot_i;
         end
         default: begin
            imm_o = '0;
            rot_o = '0;
         end
      endcase
   end

endmodule

// File: rtl/rotimm_check.sv
module rotimm_check #(
   parameter int unsigned DATA_W   = rimm_pkg::DEF_DATA_W,
   parameter int unsigned IMM_W    = rimm_pkg::DEF_IMM_W,
   parameter int unsigned ROT_STEP = rimm_pkg::DEF_ROT_STEP,
   localparam int unsigned NUM_ROT = DATA_W / ROT_STEP,
   localparam int unsigned ROT_W   = $clog2(NUM_ROT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              valid_out,
   output logic              direct_ok,
   output logic              inverted_ok,
   output logic [IMM_W-1:0]  imm_out,
   output logic [ROT_W-1:0]  rot_out
);

   initial begin
      assert (ROT_STEP > 0 && (DATA_W % ROT_STEP) == 0)
         else $error("rotation step must divide the data width");
      assert (IMM_W > 0 && IMM_W < DATA_W)
         else $error("immediate must be narrower than the data word");
      assert ((1 << ROT_W) == NUM_ROT)
         else $error("rotation count must be a power of two");
   end

   logic              dir_found, inv_found;
   logic [IMM_W-1:0]  dir_imm, inv_imm, sel_imm;
   logic [ROT_W-1:0]  dir_rot, inv_rot, sel_rot;
   logic [DATA_W-1:0] data_inv;

   assign data_inv = ~data_in;

   rimm_search #(
      .DATA_W   (DATA_W),
      .IMM_W    (IMM_W),
      .ROT_STEP (ROT_STEP)
   ) u_dir (
      .word_i  (data_in),
      .found_o (dir_found),
      .imm_o   (dir_imm),
      .rot_o   (dir_rot)
   );

   rimm_search #(
      .DATA_W   (DATA_W),
      .IMM_W    (IMM_W),
      .ROT_STEP (ROT_STEP)
   ) u_inv (
      .word_i  (data_inv),
      .found_o (inv_found),
      .imm_o   (inv_imm),
      .rot_o   (inv_rot)
   );

   rimm_select #(
      .IMM_W (IMM_W),
      .ROT_W (ROT_W)
   ) u_sel (
      .dir_found_i (dir_found),
      .dir_imm_i   (dir_imm),
      .dir_rot_i   (dir_rot),
      .inv_found_i (inv_found),
      .inv_imm_i   (inv_imm),
      .inv_rot_i   (inv_rot),
      .imm_o       (sel_imm),
      .rot_o       (sel_rot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_out   <= 1'b0;
         direct_ok   <= 1'b0;
         inverted_ok <= 1'b0;
         imm_out     <= '0;
         rot_out     <= '0;
      end else begin
         valid_out <= valid_in;
         if (valid_in) begin
            direct_ok   <= dir_found;
            inverted_ok <= inv_found;
            imm_out     <= sel_imm;
            rot_out     <= sel_rot;
         end
      end
   end

endmodule

// File: rtl/rotimm_check_sva.sv
module rotimm_check_sva #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 8,
   parameter int unsigned ROT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              valid_in,
   input logic [DATA_W-1:0] data_in,
   input logic              valid_out,
   input logic              direct_ok,
   input logic              inverted_ok,
   input logic [IMM_W-1:0]  imm_out,
   input logic [ROT_W-1:0]  rot_out
);

   localparam int unsigned STEP = DATA_W / (1 << ROT_W);

   function automatic logic [DATA_W-1:0] expand(input logic [IMM_W-1:0] v,
                                                input logic [ROT_W-1:0] r);
      logic [2*DATA_W-1:0] dd;
      dd = {{(DATA_W-IMM_W){1'b0}}, v, {(DATA_W-IMM_W){1'b0}}, v};
      dd = dd >> (int'(r) * STEP);
      return dd[DATA_W-1:0];
   endfunction

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);

   assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> !valid_out);

   assert_small_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in && (data_in[DATA_W-1:IMM_W] == '0) |=>
         direct_ok && (rot_out == '0) && (imm_out == $past(data_in[IMM_W-1:0])));

   assert_direct_roundtrip_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_out && direct_ok |-> expand(imm_out, rot_out) == $past(data_in));

   assert_invert_roundtrip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_out && !direct_ok && inverted_ok |-> expand(imm_out, rot_out) == ~$past(data_in));

   assert_none_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_out && !direct_ok && !inverted_ok |-> (imm_out == '0) && (rot_out == '0));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> $stable(direct_ok) && $stable(inverted_ok)
                    && $stable(imm_out) && $stable(rot_out));

endmodule

bind rotimm_check rotimm_check_sva #(
   .DATA_W (DATA_W),
   .IMM_W  (IMM_W),
   .ROT_W  (ROT_W)
) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .valid_in    (valid_in),
   .data_in     (data_in),
   .valid_out   (valid_out),
   .direct_ok   (direct_ok),
   .inverted_ok (inverted_ok),
   .imm_out     (imm_out),
   .rot_out     (rot_out)
);

// File: tb/rotimm_check_bench.sv
`timescale 1ns/1ps
module rotimm_check_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        valid_in;
   logic [31:0] data_in;
   logic        valid_out, direct_ok, inverted_ok;
   logic [7:0]  imm_out;
   logic [3:0]  rot_out;

   int vectors = 0;
   int miscompares = 0;

   // Expected state after the most recent edge
   bit         e_v, e_d, e_i;
   logic [7:0] e_imm;
   logic [3:0] e_rot;
   string      e_tag;

   always #2.5 clk = ~clk;

   rotimm_check u_rotimm_check (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid_in    (valid_in),
      .data_in     (data_in),
      .valid_out   (valid_out),
      .direct_ok   (direct_ok),
      .inverted_ok (inverted_ok),
      .imm_out     (imm_out),
      .rot_out     (rot_out)
   );

   // Behavioural model: try each even left rotation, first fit wins
   function automatic void fit_search(input logic [31:0] x, output bit ok,
                                      output logic [7:0] imm, output logic [3:0] rot);
      logic [63:0] dd;
      logic [31:0] y;
      ok = 0; imm = '0; rot = '0;
      dd = {x, x};
      for (int k = 0; k < 16; k++) begin
         y = dd[63 - 2*k -: 32];
         if (!ok && y[31:8] == 24'h0) begin
            ok = 1; imm = y[7:0]; rot = 4'(k);
         end
      end
   endfunction

   function automatic logic [31:0] spin_right(input logic [7:0] v, input int r);
      logic [63:0] dd;
      dd = {24'h0, v, 24'h0, v} >> (2*r);
      return dd[31:0];
   endfunction

   task automatic compare();
      bit bad = 0;
      vectors++;
      if (valid_out !== e_v) begin
         bad = 1;
         $display("FAIL R1 valid_out actual=%0b expected=%0b (%s)", valid_out, e_v, e_tag);
      end
      if (direct_ok !== e_d) begin
         bad = 1;
         $display("FAIL %s direct_ok actual=%0b expected=%0b", e_tag, direct_ok, e_d);
      end
      if (inverted_ok !== e_i) begin
         bad = 1;
         $display("FAIL %s inverted_ok actual=%0b expected=%0b", e_tag, inverted_ok, e_i);
      end
      if (imm_out !== e_imm) begin
         bad = 1;
         $display("FAIL %s imm_out actual=%02h expected=%02h", e_tag, imm_out, e_imm);
      end
      if (rot_out !== e_rot) begin
         bad = 1;
         $display("FAIL %s rot_out actual=%0d expected=%0d", e_tag, rot_out, e_rot);
      end
      if (bad) miscompares++;
   endtask

   // Check the result of the previous edge, then drive the next input
   task automatic step(input bit vin, input logic [31:0] d, input string tag);
      bit dok, iok;
      logic [7:0] dimm, iimm;
      logic [3:0] drot, irot;
      @(negedge clk);
      compare();
      valid_in = vin;
      data_in  = d;
      e_v = vin;
      if (vin) begin
         fit_search(d, dok, dimm, drot);
         fit_search(~d, iok, iimm, irot);
         e_d = dok;
         e_i = iok;
         if (dok) begin e_imm = dimm; e_rot = drot; end
         else if (iok) begin e_imm = iimm; e_rot = irot; end
         else begin e_imm = '0; e_rot = '0; end
         e_tag = tag;
      end else begin
         e_tag = "R9";
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      rst_n = 1'b0; valid_in = 1'b0; data_in = '0;
      e_v = 0; e_d = 0; e_i = 0; e_imm = '0; e_rot = '0; e_tag = "R10";
      repeat (3) @(negedge clk);
      compare();                                  // R10 reset state
      rst_n = 1'b1;

      // R2: small values, direct with rotate 0
      step(1, 32'h0000_0000, "R2");
      step(1, 32'h0000_00FF, "R2");
      step(1, 32'h0000_005A, "R2");
      // R4: lowest rotation among several fits
      step(1, 32'h0000_0003, "R4");
      step(1, 32'h0000_00C0, "R4");
      // R8: wrapping and large rotations
      step(1, 32'hF000_000F, "R8");
      step(1, 32'h0000_0400, "R8");
      step(1, 32'h0000_03FC, "R8");
      step(1, 32'hFF00_0000, "R3");
      // R6: complement path
      step(1, 32'hFFFF_FFF6, "R6");
      step(1, 32'hFFFF_FFFF, "R6");
      step(1, 32'hFFFF_FBFF, "R5");
      // R7: neither form
      step(1, 32'h1999_999A, "R7");
      step(1, 32'h0000_0101, "R7");
      // R9: idle cycles keep the last result
      step(0, 32'h0000_0001, "R9");
      step(0, 32'hDEAD_BEEF, "R9");
      step(1, 32'h0000_0055, "R2");
      step(0, 32'hFFFF_FFFF, "R9");

      for (int n = 0; n < 200; n++) begin
         step(1, spin_right(8'($urandom), int'($urandom % 16)), "R3");
         if (n % 7 == 3) step(0, $urandom, "R9");
      end
      for (int n = 0; n < 100; n++)
         step(1, ~spin_right(8'($urandom), int'($urandom % 16)), "R5");
      for (int n = 0; n < 60; n++)
         step(1, -32'(int'($urandom % 256) + 1), "R6");
      for (int n = 0; n < 150; n++)
         step(1, $urandom, "R7");
      for (int n = 0; n < 40; n++)
         step(1, 32'($urandom % 256), "R2");
      step(0, 32'h0, "R9");
      step(0, 32'h0, "R1");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule